// File: doc/BRIEF.md
# Parallel-State Byte Pattern Automaton

This block scans a byte stream for patterns described as a non-deterministic automaton. Each automaton state has its own flip-flop, so any mix of states can be live at once. One byte is consumed on every clock where the stream valid is high. The number of live states never changes this rate. After each consumed byte, the block pulses a match output if any state flagged as accepting is live.

Software builds the automaton through a write port, one state per write. Each state record holds four things: the byte the state answers to, a mask of the states that may lead into it, a flag that lets the state fire straight from the stream with no predecessor, and a flag that marks it as accepting. Chaining two sub-patterns works by naming the last state of the first as a predecessor of the first state of the second. Either-or patterns work by giving two branches the same entry condition and making both branches feed the same following states. Entry-flagged states are re-armed on every byte, so a match may start at any offset. A synchronous clear empties every state, for example between packets.

Top module: `nfa_regex_match`

## Requirements
- R1: After reset every state is inactive, match_o is low, and every state record is zero (no entry flag, empty predecessor mask, not accepting). With these records no byte can make any state active.
- R2: On a clock where in_valid_i is high and clr_i is low, state i is active after the edge exactly when in_data_i equals its label and either its entry flag is set or some state in its predecessor mask (bit j of the mask means state j) was active before the edge.
- R3: Entry-flagged states are evaluated on every consumed byte whatever the other states hold, so a pattern is found at any stream offset, including overlapping occurrences.
- R4: Several states may be active after the same byte; each state follows R2 independently.
- R5: On a clock with in_valid_i low and clr_i low, every state keeps its value and match_o is low after the edge.
- R6: clr_i high makes every state inactive and match_o low after the edge, and it takes priority over in_valid_i.
- R7: match_o is high for one cycle, in the cycle after a consumed byte, exactly when at least one accepting state is active after that byte.
- R8: A write (cfg_we_i high) replaces the record of state cfg_idx_i at the edge, but it is ignored on any clock where in_valid_i is high.
- R9: Chaining: a state whose only predecessor is the last state of a first sub-pattern becomes active only on the byte directly after that sub-pattern completes.
- R10: Either-or: a state whose predecessor mask names the last states of two branches becomes active after either branch completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr_i | input | 1 | Synchronous clear of all states |
| in_valid_i | input | 1 | Stream byte valid |
| in_data_i | input | CHAR_W | Stream byte |
| cfg_we_i | input | 1 | State record write strobe |
| cfg_idx_i | input | IDX_W | Index of the state being written |
| cfg_label_i | input | CHAR_W | Byte the state answers to |
| cfg_pred_i | input | NUM_STATES | Predecessor mask, bit j names state j |
| cfg_start_i | input | 1 | Entry flag: state may fire with no predecessor |
| cfg_accept_i | input | 1 | Accepting flag |
| match_o | output | 1 | Match pulse |
| active_o | output | NUM_STATES | Current state vector, bit i is state i |

## Verification
A chained three-byte pattern is fed streams with noise, restarts and back-to-back repeats. This shows apart a block that really re-arms on every byte from one that only tracks a single attempt. An overlapping two-state pattern on a run of equal bytes keeps several states live at once. An either-or pattern proves that both branches reach the shared successor. Gaps in valid, clears in mid-pattern and writes attempted during streaming show the hold, clear-priority and write-blocking rules. Many random automata over a three-letter alphabet, with random valid gaps, are compared each cycle against a software model of the transition rule.

// File: rtl/nfa_pkg.sv
package nfa_pkg;
  localparam int unsigned NFA_CHAR_W = 8;
  localparam int unsigned NFA_STATES = 8;

  // update kind applied to the state vector on a clock edge
  typedef enum logic [1:0] {
    UPD_HOLD  = 2'd0,
    UPD_STEP  = 2'd1,
    UPD_CLEAR = 2'd2
  } nfa_upd_e;
endpackage

// File: rtl/nfa_rst_sync.sv
module nfa_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/nfa_cfg_store.sv
module nfa_cfg_store #(
  parameter int unsigned N     = 8,
  parameter int unsigned CW    = 8,
  parameter int unsigned IW    = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [IW-1:0]   wr_idx_i,
  input  logic [CW-1:0]   wr_label_i,
  input  logic [N-1:0]    wr_pred_i,
  input  logic            wr_start_i,
  input  logic            wr_accept_i,
  output logic [N*CW-1:0] label_flat_o,
  output logic [N*N-1:0]  pred_flat_o,
  output logic [N-1:0]    start_vec_o,
  output logic [N-1:0]    accept_vec_o
);
  for (genvar i = 0; i < N; i++) begin : g_rec
    logic [CW-1:0] label_q, label_d;
    logic [N-1:0]  pred_q, pred_d;
    logic          start_q, start_d;
    logic          accept_q, accept_d;
    logic          sel;

    assign sel = wr_en_i && (wr_idx_i == IW'(i));

    always_comb begin
      label_d  = label_q;
      pred_d   = pred_q;
      start_d  = start_q;
      accept_d = accept_q;
      if (sel) begin
        label_d  = wr_label_i;
        pred_d   = wr_pred_i;
        start_d  = wr_start_i;
        accept_d = wr_accept_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        label_q  <= '0;
        pred_q   <= '0;
        start_q  <= 1'b0;
        accept_q <= 1'b0;
      end else if (sel) begin
        label_q  <= label_d;
        pred_q   <= pred_d;
        start_q  <= start_d;
        accept_q <= accept_d;
      end
    end

    assign label_flat_o[i*CW +: CW] = label_q;
    assign pred_flat_o[i*N +: N]    = pred_q;
    assign start_vec_o[i]           = start_q;
    assign accept_vec_o[i]          = accept_q;
  end
endmodule

// File: rtl/nfa_state_vec.sv
module nfa_state_vec
  import nfa_pkg::*;
#(
  parameter int unsigned N  = 8,
  parameter int unsigned CW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  nfa_upd_e        upd_i,
  input  logic [CW-1:0]   data_i,
  input  logic [N*CW-1:0] label_flat_i,
  input  logic [N*N-1:0]  pred_flat_i,
  input  logic [N-1:0]    start_vec_i,
  input  logic [N-1:0]    accept_vec_i,
  output logic [N-1:0]    active_o,
  output logic            match_o
);
  logic [N-1:0] active_q, active_d;
  logic [N-1:0] hit;
  logic         match_q, match_d;
  logic         upd_en;

  for (genvar i = 0; i < N; i++) begin : g_cell
    logic lbl_eq;
    logic armed;
    assign lbl_eq = (label_flat_i[i*CW +: CW] == data_i);
    assign armed  = start_vec_i[i] || (|(pred_flat_i[i*N +: N] & active_q));
    assign hit[i] = lbl_eq && armed;
  end

  always_comb begin
    active_d = active_q;
    match_d  = 1'b0;
    unique case (upd_i)
      UPD_CLEAR: active_d = '0;
      UPD_STEP: begin
        active_d = hit;
        match_d  = |(hit & accept_vec_i);
      end
      default: active_d = active_q;
    endcase
  end

  assign upd_en = (upd_i != UPD_HOLD) || match_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= '0;
      match_q  <= 1'b0;
    end else if (upd_en) begin
      active_q <= active_d;
      match_q  <= match_d;
    end
  end

  assign active_o = active_q;
  assign match_o  = match_q;
endmodule

// File: rtl/nfa_regex_match.sv
module nfa_regex_match
  import nfa_pkg::*;
#(
  parameter int unsigned NUM_STATES = NFA_STATES,
  parameter int unsigned CHAR_W     = NFA_CHAR_W,
  localparam int unsigned IDX_W     = (NUM_STATES > 1) ? $clog2(NUM_STATES) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  in_valid_i,
  input  logic [CHAR_W-1:0]     in_data_i,
  input  logic                  cfg_we_i,
  input  logic [IDX_W-1:0]      cfg_idx_i,
  input  logic [CHAR_W-1:0]     cfg_label_i,
  input  logic [NUM_STATES-1:0] cfg_pred_i,
  input  logic                  cfg_start_i,
  input  logic                  cfg_accept_i,
  output logic                  match_o,
  output logic [NUM_STATES-1:0] active_o
);
  logic                           rst_n_q;
  logic                           cfg_wr;
  nfa_upd_e                       upd;
  logic [NUM_STATES*CHAR_W-1:0]   label_flat;
  logic [NUM_STATES*NUM_STATES-1:0] pred_flat;
  logic [NUM_STATES-1:0]          start_vec;
  logic [NUM_STATES-1:0]          accept_vec;

  nfa_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_q)
  );

  // records may only change while the stream is idle
  assign cfg_wr = cfg_we_i && !in_valid_i;

  always_comb begin
    if (clr_i)           upd = UPD_CLEAR;
    else if (in_valid_i) upd = UPD_STEP;
    else                 upd = UPD_HOLD;
  end

  nfa_cfg_store #(
    .N  (NUM_STATES),
    .CW (CHAR_W),
    .IW (IDX_W)
  ) u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_n_q),
    .wr_en_i      (cfg_wr),
    .wr_idx_i     (cfg_idx_i),
    .wr_label_i   (cfg_label_i),
    .wr_pred_i    (cfg_pred_i),
    .wr_start_i   (cfg_start_i),
    .wr_accept_i  (cfg_accept_i),
    .label_flat_o (label_flat),
    .pred_flat_o  (pred_flat),
    .start_vec_o  (start_vec),
    .accept_vec_o (accept_vec)
  );

  nfa_state_vec #(
    .N  (NUM_STATES),
    .CW (CHAR_W)
  ) u_states (
    .clk_i        (clk_i),
    .rst_ni       (rst_n_q),
    .upd_i        (upd),
    .data_i       (in_data_i),
    .label_flat_i (label_flat),
    .pred_flat_i  (pred_flat),
    .start_vec_i  (start_vec),
    .accept_vec_i (accept_vec),
    .active_o     (active_o),
    .match_o      (match_o)
  );
endmodule

// File: rtl/nfa_regex_chk.sv
module nfa_regex_chk #(
  parameter int unsigned N = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         clr_i,
  input logic         in_valid_i,
  input logic         cfg_we_i,
  input logic [N-1:0] active_o,
  input logic         match_o,
  input logic [N-1:0] accept_vec,
  input logic [N-1:0] start_vec
);
  // R2
  state_needs_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((active_o & ~$past(active_o)) != '0) |-> $past(in_valid_i));

  // R5
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_valid_i && !clr_i) |=> ($stable(active_o) && !match_o));

  // R6
  clear_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (active_o == '0 && !match_o));

  // R7
  match_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> ((active_o & accept_vec) != '0));

  // R7
  match_after_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> $past(in_valid_i));

  // R8
  cfg_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && in_valid_i) |=> ($stable(accept_vec) && $stable(start_vec)));
endmodule

bind nfa_regex_match nfa_regex_chk #(.N(NUM_STATES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_n_q),
  .clr_i      (clr_i),
  .in_valid_i (in_valid_i),
  .cfg_we_i   (cfg_we_i),
  .active_o   (active_o),
  .match_o    (match_o),
  .accept_vec (accept_vec),
  .start_vec  (start_vec)
);

// File: tb/nfa_regex_match_tb.sv
`timescale 1ns/1ps
module nfa_regex_match_tb;
  localparam int N  = 8;
  localparam int CW = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          clr;
  logic          in_valid;
  logic [CW-1:0] in_data;
  logic          cfg_we;
  logic [IW-1:0] cfg_idx;
  logic [CW-1:0] cfg_label;
  logic [N-1:0]  cfg_pred;
  logic          cfg_start;
  logic          cfg_accept;
  logic          match;
  logic [N-1:0]  active;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // software model
  logic [CW-1:0] m_lab [N];
  logic [N-1:0]  m_pred[N];
  logic [N-1:0]  m_st;
  logic [N-1:0]  m_acc;
  logic [N-1:0]  m_act;
  logic          m_match;

  always #2.5 clk = ~clk;

  nfa_regex_match #(.NUM_STATES(N), .CHAR_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .in_valid_i(in_valid),
    .in_data_i(in_data), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx),
    .cfg_label_i(cfg_label), .cfg_pred_i(cfg_pred), .cfg_start_i(cfg_start),
    .cfg_accept_i(cfg_accept), .match_o(match), .active_o(active)
  );

  function automatic logic [N-1:0] model_next(input logic [CW-1:0] b);
    logic [N-1:0] nx;
    nx = '0;
    for (int i = 0; i < N; i++)
      nx[i] = (m_lab[i] == b) && (m_st[i] || ((m_pred[i] & m_act) != '0));
    return nx;
  endfunction

  task automatic check(input string tag, input logic [N-1:0] ea, input logic em);
    checks++;
    if (active !== ea || match !== em) begin
      errors++;
      $display("FAIL %s active=%b match=%b expected active=%b match=%b",
               tag, active, match, ea, em);
    end
  endtask

  // called at a negedge; returns at the following negedge
  task automatic step(input string tag, input logic v, input logic [CW-1:0] b, input logic c);
    logic [N-1:0] ea;
    logic em;
    in_valid = v; in_data = b; clr = c;
    if (c) begin
      ea = '0; em = 1'b0;
    end else if (v) begin
      ea = model_next(b); em = (ea & m_acc) != '0;
    end else begin
      ea = m_act; em = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; clr = 1'b0;
    m_act = ea; m_match = em;
    check(tag, ea, em);
  endtask

  task automatic feed(input string tag, input string s);
    for (int k = 0; k < s.len(); k++) step(tag, 1'b1, s[k], 1'b0);
  endtask

  // blocked=1 drives in_valid together with the write
  task automatic wr(input int idx, input logic [CW-1:0] lab, input logic [N-1:0] pr,
                    input logic st, input logic ac, input logic blocked);
    cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_label = lab; cfg_pred = pr;
    cfg_start = st; cfg_accept = ac; in_valid = blocked; in_data = 8'h00;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0; in_valid = 1'b0;
    if (!blocked) begin
      m_lab[idx] = lab; m_pred[idx] = pr; m_st[idx] = st; m_acc[idx] = ac;
    end else begin
      m_act = model_next(8'h00);
    end
  endtask

  task automatic wipe();
    for (int i = 0; i < N; i++) wr(i, 8'h00, '0, 1'b0, 1'b0, 1'b0);
    step("R6 wipe", 1'b0, 8'h00, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; in_valid = 1'b0; in_data = '0; cfg_we = 1'b0;
    cfg_idx = '0; cfg_label = '0; cfg_pred = '0; cfg_start = 1'b0; cfg_accept = 1'b0;
    for (int i = 0; i < N; i++) begin m_lab[i] = '0; m_pred[i] = '0; end
    m_st = '0; m_acc = '0; m_act = '0; m_match = 1'b0;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", '0, 1'b0);
    // R1: zeroed records never fire, even on byte 0x00
    step("R1 zero records", 1'b1, 8'h00, 1'b0);

    // R9 chained "abc"
    wr(0, "a", 8'h00, 1'b1, 1'b0, 1'b0);
    wr(1, "b", 8'h01, 1'b0, 1'b0, 1'b0);
    wr(2, "c", 8'h02, 1'b0, 1'b1, 1'b0);
    feed("R9 chain", "xxabcab");
    step("R7 match pulse", 1'b1, "c", 1'b0);
    if (match !== 1'b1) begin errors++; $display("FAIL R7 match=%b expected 1", match); end
    checks++;
    feed("R3 any offset", "abcabcaabc");
    feed("R9 broken chain", "abxc");
    // R5: gap in the middle of a pattern
    feed("R5 pre", "ab");
    step("R5 hold", 1'b0, "z", 1'b0);
    step("R5 hold", 1'b0, "z", 1'b0);
    step("R5 resume", 1'b1, "c", 1'b0);
    // R6: clear with valid high, clear wins
    feed("R6 pre", "ab");
    step("R6 clear priority", 1'b1, "c", 1'b1);
    step("R6 after clear", 1'b1, "c", 1'b0);
    // R8: write during streaming is ignored; idle write takes
    wr(2, "c", 8'h02, 1'b0, 1'b0, 1'b1);
    feed("R8 blocked write", "abc");
    wr(2, "c", 8'h02, 1'b0, 1'b0, 1'b0);
    feed("R8 idle write", "abc");

    // R4 overlapping "aa" on a run of a's
    wipe();
    wr(0, "a", 8'h00, 1'b1, 1'b0, 1'b0);
    wr(1, "a", 8'h01, 1'b0, 1'b1, 1'b0);
    feed("R4 multi active", "aaaab");
    if (m_act != '0) begin errors++; $display("FAIL R4 model"); end

    // R10 (ab|cd)e
    wipe();
    wr(0, "a", 8'h00, 1'b1, 1'b0, 1'b0);
    wr(1, "b", 8'h01, 1'b0, 1'b0, 1'b0);
    wr(2, "c", 8'h00, 1'b1, 1'b0, 1'b0);
    wr(3, "d", 8'h04, 1'b0, 1'b0, 1'b0);
    wr(4, "e", 8'h0A, 1'b0, 1'b1, 1'b0);
    feed("R10 either-or", "abecdeadecbe");

    // R2 random automata and streams
    for (int t = 0; t < 40; t++) begin
      for (int i = 0; i < N; i++)
        wr(i, 8'h61 + 8'($urandom_range(0, 2)), N'($urandom),
           ($urandom_range(0, 2) == 0), ($urandom_range(0, 3) == 0), 1'b0);
      for (int k = 0; k < 60; k++)
        step("R2 random", ($urandom_range(0, 4) != 0),
             8'h61 + 8'($urandom_range(0, 2)), ($urandom_range(0, 40) == 0));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule